// File: doc/BRIEF.md
# Rightmost-Bit Manipulation Unit

This unit takes one data word and a function code and returns one of nine operations on the lowest set bit, the lowest clear bit, or the trailing run of equal bits at the bottom of the word. Every function is built only from the word-wide carry chains x+1, x-1 and -x, combined with AND, OR, XOR and NOT. No priority encoder or bit scan is used.

A zero flag goes with each result. This makes the unit usable as a one-step test. With the "clear lowest set bit" function, a zero result means the operand is a power of two or zero. With the "clear lowest run of ones" function, a zero result means the operand is a single contiguous block of ones, of the form 2^j - 2^k, or zero.

The result can leave through an optional output register. The register loads on a valid strobe, and a valid flag marks the cycle in which the loaded result appears.

Top module: `rmb_unit`

## Requirements
- R1: Function code 0 clears the lowest set bit of the operand, x & (x-1). An operand of 0 gives 0.
- R2: Function code 1 sets the lowest clear bit, x | (x+1). An all-ones operand stays all ones.
- R3: Function code 2 clears the trailing ones, x & (x+1), so an operand with bit 0 clear passes through unchanged. Function code 3 sets the trailing zeros, x | (x-1).
- R4: Function code 4 returns a word holding only the lowest clear bit of the operand, ~x & (x+1). Function code 5 returns only the lowest set bit, x & -x. Each gives 0 when no such bit exists.
- R5: Function code 6 returns a mask of the lowest set bit and all bits below it, x ^ (x-1). This is all ones for x = 0 and 1 when bit 0 is set. Function code 7 returns a mask of the lowest clear bit and all bits below it, x ^ (x+1).
- R6: Function code 8 clears the lowest contiguous run of ones, ((x & -x) + x) & x. For example, 0x5C gives 0x40.
- R7: Function codes 9 to 15 give a result of 0.
- R8: The zero flag is 1 exactly when the result that goes with it is 0.
- R9: With the output register present (REG_OUT=1), a cycle with in_valid_i high loads the result and flag at the clock edge, and out_valid_o is high in the following cycle. After a cycle with in_valid_i low, out_valid_o is low and the result and flag keep their previous values.
- R10: While rst_ni is low, out_valid_o is 0, res_o is 0 and zero_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand and function code are valid this cycle |
| func_i | input | 4 | Function code (0 to 8 are used, the rest give 0) |
| x_i | input | 32 | Operand |
| res_o | output | 32 | Result |
| zero_o | output | 1 | Result is zero |
| out_valid_o | output | 1 | res_o and zero_o carry a newly loaded result |

## Verification
With the default registered output, every result and its zero flag are due exactly one clock edge after the cycle in which in_valid_i was high. The bench drives inputs just after a falling edge and checks at the next falling edge, so the single capturing edge lies between drive and check. For a cycle without in_valid_i, the bench checks at that same point that out_valid_o is low and that the result and flag still equal the last loaded pair. Expected values come from a bit-by-bit scan model that is computed independently of the carry chains.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
  typedef enum logic [3:0] {
    FN_CLR_LOW_SET  = 4'd0,
    FN_SET_LOW_CLR  = 4'd1,
    FN_CLR_TRAIL_1  = 4'd2,
    FN_SET_TRAIL_0  = 4'd3,
    FN_ISO_LOW_CLR  = 4'd4,
    FN_ISO_LOW_SET  = 4'd5,
    FN_MSK_LOW_SET  = 4'd6,
    FN_MSK_LOW_CLR  = 4'd7,
    FN_CLR_LOW_RUN  = 4'd8
  } rmb_func_e;
endpackage

// File: rtl/rmb_terms.sv
// Carry-chain terms shared by all functions.
module rmb_terms #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] inc_o,
  output logic [WIDTH-1:0] dec_o,
  output logic [WIDTH-1:0] neg_o
);
  localparam logic [WIDTH-1:0] One = {{(WIDTH-1){1'b0}}, 1'b1};

  assign inc_o = x_i + One;
  assign dec_o = x_i - One;
  assign neg_o = ~x_i + One;
endmodule

// File: rtl/rmb_select.sv
module rmb_select
  import rmb_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned FN_W  = 4
) (
  input  logic [FN_W-1:0]  func_i,
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] inc_i,
  input  logic [WIDTH-1:0] dec_i,
  input  logic [WIDTH-1:0] neg_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] low_set;

  assign low_set = x_i & neg_i;

  always_comb begin
    unique case (func_i)
      FN_CLR_LOW_SET: res_o = x_i & dec_i;
      FN_SET_LOW_CLR: res_o = x_i | inc_i;
      FN_CLR_TRAIL_1: res_o = x_i & inc_i;
      FN_SET_TRAIL_0: res_o = x_i | dec_i;
      FN_ISO_LOW_CLR: res_o = ~x_i & inc_i;
      FN_ISO_LOW_SET: res_o = low_set;
      FN_MSK_LOW_SET: res_o = x_i ^ dec_i;
      FN_MSK_LOW_CLR: res_o = x_i ^ inc_i;
      FN_CLR_LOW_RUN: res_o = (low_set + x_i) & x_i;
      default:        res_o = '0;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/rmb_out_stage.sv
module rmb_out_stage #(
  parameter int unsigned WIDTH   = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             zero_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             out_valid_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o       <= '0;
        zero_o      <= 1'b1;
        out_valid_o <= 1'b0;
      end else begin
        out_valid_o <= in_valid_i;
        if (in_valid_i) begin
          res_o  <= res_i;
          zero_o <= zero_i;
        end
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk  = clk_i ^ rst_ni;
    assign res_o       = res_i;
    assign zero_o      = zero_i;
    assign out_valid_o = in_valid_i;
  end
endmodule

// File: rtl/rmb_unit.sv
module rmb_unit #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned FN_W    = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [FN_W-1:0]  func_i,
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             out_valid_o
);
  logic [WIDTH-1:0] inc, dec, neg, res_c;
  logic             zero_c;

  rmb_terms #(.WIDTH(WIDTH)) i_terms (
    .x_i  (x_i),
    .inc_o(inc),
    .dec_o(dec),
    .neg_o(neg)
  );

  rmb_select #(.WIDTH(WIDTH), .FN_W(FN_W)) i_select (
    .func_i(func_i),
    .x_i   (x_i),
    .inc_i (inc),
    .dec_i (dec),
    .neg_i (neg),
    .res_o (res_c),
    .zero_o(zero_c)
  );

  rmb_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .res_i      (res_c),
    .zero_i     (zero_c),
    .res_o      (res_o),
    .zero_o     (zero_o),
    .out_valid_o(out_valid_o)
  );
endmodule

// File: rtl/rmb_unit_chk.sv
module rmb_unit_chk #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned FN_W    = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [FN_W-1:0]  func_i,
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             out_valid_o
);
  if (REG_OUT) begin : g_reg_props
    a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);

    a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !out_valid_o && $stable(res_o) && $stable(zero_o));

    a_r8_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (zero_o == (res_o == '0)));

    a_r4_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && (func_i == 4'd4 || func_i == 4'd5) |=> $onehot0(res_o));

    a_r1_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && func_i == 4'd0 |=>
        ((res_o & ~$past(x_i)) == '0) && ($countones(res_o) + 1 >= $countones($past(x_i))));

    a_r5_low_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && (func_i == 4'd6 || func_i == 4'd7) |=> ((res_o & (res_o + 1'b1)) == '0) && res_o[0]);

    a_r7_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && func_i > 4'd8 |=> res_o == '0);
  end

  always_comb begin
    if (!rst_ni && REG_OUT) a_r10_reset_idle: assert (!out_valid_o || $isunknown(out_valid_o));
  end
endmodule

bind rmb_unit rmb_unit_chk #(.WIDTH(WIDTH), .FN_W(FN_W), .REG_OUT(REG_OUT)) i_rmb_unit_chk (.*);

// File: tb/test_rmb_unit.sv
`timescale 1ns/1ps
module test_rmb_unit;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [3:0]    func = '0;
  logic [W-1:0]  x = '0;
  logic [W-1:0]  res;
  logic          zero;
  logic          out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expectation for the next sampling point
  bit           pend_v = 1'b0;
  logic [W-1:0] hold_res = '0;
  logic         hold_zero = 1'b1;
  string        pend_tag = "R10";

  always #2.5 clk = ~clk;

  rmb_unit i_rmb_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .func_i(func), .x_i(x),
    .res_o(res), .zero_o(zero), .out_valid_o(out_valid)
  );

  // bit-scan reference model
  function automatic logic [W-1:0] ref_op(input logic [3:0] f, input logic [W-1:0] v);
    logic [W-1:0] r;
    int lo1, lo0;
    bit run;
    lo1 = -1; lo0 = -1;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) lo1 = i; else lo0 = i;
    end
    r = v;
    case (f)
      4'd0: if (lo1 >= 0) r[lo1] = 1'b0;
      4'd1: if (lo0 >= 0) r[lo0] = 1'b1;
      4'd2: for (int i = 0; i < W; i++) if (lo0 < 0 || i < lo0) r[i] = 1'b0;
      4'd3: for (int i = 0; i < W; i++) if (lo1 < 0 || i < lo1) r[i] = 1'b1;
      4'd4: begin r = '0; if (lo0 >= 0) r[lo0] = 1'b1; end
      4'd5: begin r = '0; if (lo1 >= 0) r[lo1] = 1'b1; end
      4'd6: begin r = '0; for (int i = 0; i < W; i++) if (lo1 < 0 || i <= lo1) r[i] = 1'b1; end
      4'd7: begin r = '0; for (int i = 0; i < W; i++) if (lo0 < 0 || i <= lo0) r[i] = 1'b1; end
      4'd8: begin
        run = 1'b1;
        for (int i = 0; i < W; i++) begin
          if (lo1 >= 0 && i >= lo1 && run) begin
            if (v[i]) r[i] = 1'b0; else run = 1'b0;
          end
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] f);
    case (f)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // sample at falling edge, then drive the next cycle
  task automatic step(input bit v, input logic [3:0] f, input logic [W-1:0] val);
    logic [W-1:0] e;
    @(negedge clk);
    chk("R9 valid", {31'd0, out_valid}, {31'd0, pend_v});
    chk({pend_tag, " result"}, res, hold_res);
    chk("R8 zero", {31'd0, zero}, {31'd0, hold_zero});
    in_valid = v; func = f; x = val;
    if (v) begin
      e = ref_op(f, val);
      hold_res = e;
      hold_zero = (e == '0);
      pend_tag = tag_of(f);
    end else begin
      pend_tag = "R9 hold";
    end
    pend_v = v;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] vecs [10];
    vecs[0] = 32'h0000_0000; vecs[1] = 32'hFFFF_FFFF; vecs[2] = 32'h0000_0058;
    vecs[3] = 32'h0000_00A7; vecs[4] = 32'h0000_005C; vecs[5] = 32'h8000_0000;
    vecs[6] = 32'h0000_0001; vecs[7] = 32'h7FFF_FFFE; vecs[8] = 32'h0FF0_0000;
    vecs[9] = 32'hDEAD_BEEF;

    // R10: reset values while rst_n low
    repeat (3) @(negedge clk);
    chk("R10 valid", {31'd0, out_valid}, 32'd0);
    chk("R10 result", res, 32'd0);
    chk("R10 zero", {31'd0, zero}, 32'd1);
    rst_n = 1'b1;

    // spot cases: R1 0x58->0x50, R2 0xA7->0xAF, R6 0x5C->0x40
    step(1'b1, 4'd0, 32'h58);
    step(1'b1, 4'd1, 32'hA7);
    step(1'b1, 4'd8, 32'h5C);
    step(1'b0, 4'd8, 32'h0);
    @(negedge clk);
    chk("R6 literal", res, 32'h40);
    chk("R9 hold valid", {31'd0, out_valid}, 32'd0);
    step(1'b0, 4'd0, 32'h0);

    // R8: power-of-two test and run-of-ones test give zero flag
    step(1'b1, 4'd0, 32'h0000_4000);
    step(1'b1, 4'd8, 32'h0FF0_0000);
    step(1'b1, 4'd8, 32'h0F0F_0000);

    // full sweep of codes over vectors, with idle gaps for R9
    for (int vi = 0; vi < 10; vi++) begin
      for (int f = 0; f < 16; f++) begin
        step(1'b1, 4'(f), vecs[vi]);
      end
      step(1'b0, 4'd3, 32'h1234_5678);
      step(1'b0, 4'd5, 32'h0);
    end

    // R7: unused codes with an operand that would give non-zero
    for (int f = 9; f < 16; f++) step(1'b1, 4'(f), 32'hFFFF_0F0F);

    step(1'b0, 4'd0, 32'h0);
    step(1'b0, 4'd0, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule